// File: doc/BRIEF.md
# Software Flow Controller (Xon/Xoff)

This block sits between a UART receiver and its receive FIFO. It compares every received character with four programmable flow characters. A resume character releases the local transmitter, and a pause character stops it. Each of these can be one character or an ordered pair of characters. Characters that take part in a completed match are removed from the stream. All other characters go on to the FIFO unchanged. An optional mode lets any clean character release a paused transmitter.

The block also watches the receive FIFO fill level against two thresholds. When the level rises to the halt threshold, it asks the serialiser to insert the pause word into the outgoing stream. When the level later drops to the resume threshold, it asks for the resume word. Each request stays up, one character at a time, until the serialiser accepts it at a byte boundary. The serialiser is expected to send a flow character ahead of any queued FIFO data. When a pause word is recognised, a sticky flag is set for the interrupt logic, which applies its own enable to that flag.

Top module: `xfc_flow_ctrl`

## Requirements
- R1: After a synchronous reset, `tx_paused`, `xoff_flag`, `fc_req` and `fwd_valid` are all 0.
- R2: In single mode (`dbl_mode`=0) with `flow_en`=1, a clean byte equal to `xoff1` sets `tx_paused` and `xoff_flag` in the cycle after the strobe, and the byte is not forwarded.
- R3: In single mode, a clean byte equal to `xon1` (and not equal to `xoff1`) clears `tx_paused` in the cycle after the strobe, and the byte is not forwarded.
- R4: In pair mode (`dbl_mode`=1), `xoff1` followed by `xoff2` as the very next strobe sets `tx_paused`, and `xon1` followed by `xon2` clears it. Neither character of a completed pair is forwarded.
- R5: In pair mode, a held first character whose next strobe does not complete the pair is forwarded in the cycle after that strobe, and the pause state is unchanged. The breaking byte is forwarded one cycle later, unless it is itself a first character, in which case it is held as a new partial match.
- R6: With `xon_any`=1, a clean byte that does not complete a pause word clears `tx_paused` and is forwarded as normal data.
- R7: A byte strobed with `rx_err`=1 never matches and never releases the pause. It is forwarded, preceded by any held first character.
- R8: A clean byte that matches nothing is forwarded unchanged on `fwd_data`, with `fwd_valid` high for one cycle, in the cycle after its strobe. Receive strobes are at least two cycles apart.
- R9: `xoff_flag` stays set until a cycle with `xoff_clr`=1. A new pause match in that same cycle keeps the flag set.
- R10: While no request is outstanding and no pause word has yet been requested, `rx_level` >= `halt_lvl` raises `fc_req` with `fc_char`=`xoff1` in the next cycle. No further pause request follows while the level stays high.
- R11: After a pause word has been requested, `rx_level` <= `resume_lvl` raises a request whose first character is `xon1`.
- R12: `fc_req` and `fc_char` hold until `fc_ack`. In pair mode the first `fc_ack` advances `fc_char` to the second character (`xoff2`/`xon2`) and the second `fc_ack` drops `fc_req`. In single mode one `fc_ack` drops it.
- R13: With `flow_en`=0, every byte is forwarded, `tx_paused` is 0 and `fc_req` is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_en | input | 1 | Software flow control enable |
| dbl_mode | input | 1 | 1 = two-character flow words |
| xon_any | input | 1 | Any clean character releases the pause |
| xon1 | input | 8 | First resume character |
| xon2 | input | 8 | Second resume character |
| xoff1 | input | 8 | First pause character |
| xoff2 | input | 8 | Second pause character |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Parity or framing error on this byte |
| fwd_valid | output | 1 | Byte written to the receive FIFO |
| fwd_data | output | 8 | Forwarded byte |
| tx_paused | output | 1 | Local transmitter held by a pause word |
| xoff_flag | output | 1 | Sticky pause-received flag |
| xoff_clr | input | 1 | Clears the sticky flag |
| rx_level | input | LVL_W | Receive FIFO fill level |
| halt_lvl | input | LVL_W | Level that requests the pause word |
| resume_lvl | input | LVL_W | Level that requests the resume word |
| fc_req | output | 1 | Request to insert a flow character |
| fc_char | output | 8 | Flow character to insert |
| fc_ack | input | 1 | Serialiser accepted `fc_char` |

## Verification
The hardest state to reach from the ports is a broken pair. In that case the block emits two forwarded bytes on consecutive cycles, in the original order, or it forwards one byte and holds the next as a new partial match. The stimulus puts pair mode on and strobes a first character followed by an unrelated byte. It then strobes a resume-first character, a pause-first character and a pause-second character in a row. The scoreboard queue requires the exact forwarded order and no extra bytes. The request path is reached by stepping `rx_level` across both thresholds, once while acknowledges are withheld and once with them.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  // partial match held between two received characters
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_OFF  = 2'd1,
    PEND_ON   = 2'd2
  } pend_e;

  // which word is being requested for insertion
  typedef enum logic {
    WORD_ON  = 1'b0,
    WORD_OFF = 1'b1
  } word_e;
endpackage

// File: rtl/xfc_rx_match.sv
module xfc_rx_match
  import xfc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flow_en,
  input  logic          dbl_mode,
  input  logic          xon_any,
  input  logic [DW-1:0] xon1,
  input  logic [DW-1:0] xon2,
  input  logic [DW-1:0] xoff1,
  input  logic [DW-1:0] xoff2,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_err,
  input  logic          xoff_clr,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data,
  output logic          tx_paused,
  output logic          xoff_flag
);
  pend_e         pend_q;
  logic [DW-1:0] held_q;
  logic          skid_v_q;
  logic [DW-1:0] skid_d_q;

  logic clean, hit_off1, hit_on1, hit_off2, hit_on2;
  logic completes, broke, new_first, single_off, single_on;
  logic set_pause, clr_pause, fwd_byte;

  always_comb begin
    clean      = rx_valid && flow_en && !rx_err;
    hit_off1   = clean && (rx_data == xoff1);
    hit_on1    = clean && (rx_data == xon1);
    hit_off2   = clean && (pend_q == PEND_OFF) && (rx_data == xoff2);
    hit_on2    = clean && (pend_q == PEND_ON)  && (rx_data == xon2);
    completes  = dbl_mode && (hit_off2 || hit_on2);
    broke      = rx_valid && (pend_q != PEND_NONE) && !completes;
    new_first  = dbl_mode && !completes && (hit_off1 || hit_on1);
    single_off = !dbl_mode && hit_off1;
    single_on  = !dbl_mode && hit_on1 && !hit_off1;
    set_pause  = single_off || (completes && pend_q == PEND_OFF);
    clr_pause  = !set_pause &&
                 (single_on || (completes && pend_q == PEND_ON) ||
                  (xon_any && clean));
    fwd_byte   = rx_valid && !(single_off || single_on || completes || new_first);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= PEND_NONE;
      held_q    <= '0;
      skid_v_q  <= 1'b0;
      skid_d_q  <= '0;
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
      tx_paused <= 1'b0;
      xoff_flag <= 1'b0;
    end else begin
      fwd_valid <= 1'b0;
      skid_v_q  <= 1'b0;
      if (skid_v_q) begin
        fwd_valid <= 1'b1;
        fwd_data  <= skid_d_q;
      end
      if (broke) begin
        // release the held first character now, the breaking byte next
        fwd_valid <= 1'b1;
        fwd_data  <= held_q;
        if (fwd_byte) begin
          skid_v_q <= 1'b1;
          skid_d_q <= rx_data;
        end
      end else if (fwd_byte) begin
        fwd_valid <= 1'b1;
        fwd_data  <= rx_data;
      end
      if (new_first) begin
        pend_q <= hit_off1 ? PEND_OFF : PEND_ON;
        held_q <= rx_data;
      end else if (rx_valid) begin
        pend_q <= PEND_NONE;
      end
      if (!flow_en)       tx_paused <= 1'b0;
      else if (set_pause) tx_paused <= 1'b1;
      else if (clr_pause) tx_paused <= 1'b0;
      if (set_pause)      xoff_flag <= 1'b1;
      else if (xoff_clr)  xoff_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/xfc_tx_request.sv
module xfc_tx_request
  import xfc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flow_en,
  input  logic             dbl_mode,
  input  logic [DW-1:0]    xon1,
  input  logic [DW-1:0]    xon2,
  input  logic [DW-1:0]    xoff1,
  input  logic [DW-1:0]    xoff2,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  input  logic             fc_ack,
  output logic             fc_req,
  output logic [DW-1:0]    fc_char
);
  word_e kind_q;
  logic  second_q;
  logic  halted_q;

  always_ff @(posedge clk) begin
    if (rst || !flow_en) begin
      fc_req   <= 1'b0;
      kind_q   <= WORD_ON;
      second_q <= 1'b0;
      halted_q <= 1'b0;
    end else if (fc_req) begin
      if (fc_ack) begin
        if (dbl_mode && !second_q) begin
          second_q <= 1'b1;
        end else begin
          fc_req   <= 1'b0;
          second_q <= 1'b0;
        end
      end
    end else if (!halted_q && rx_level >= halt_lvl) begin
      fc_req   <= 1'b1;
      kind_q   <= WORD_OFF;
      second_q <= 1'b0;
      halted_q <= 1'b1;
    end else if (halted_q && rx_level <= resume_lvl) begin
      fc_req   <= 1'b1;
      kind_q   <= WORD_ON;
      second_q <= 1'b0;
      halted_q <= 1'b0;
    end
  end

  always_comb begin
    if (kind_q == WORD_OFF) fc_char = second_q ? xoff2 : xoff1;
    else                    fc_char = second_q ? xon2  : xon1;
  end
endmodule

// File: rtl/xfc_flow_ctrl.sv
module xfc_flow_ctrl #(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flow_en,
  input  logic             dbl_mode,
  input  logic             xon_any,
  input  logic [7:0]       xon1,
  input  logic [7:0]       xon2,
  input  logic [7:0]       xoff1,
  input  logic [7:0]       xoff2,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_err,
  output logic             fwd_valid,
  output logic [7:0]       fwd_data,
  output logic             tx_paused,
  output logic             xoff_flag,
  input  logic             xoff_clr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  output logic             fc_req,
  output logic [7:0]       fc_char,
  input  logic             fc_ack
);
  localparam int DW = 8;

  xfc_rx_match #(.DW(DW)) i_match (
    .clk(clk), .rst(rst), .flow_en(flow_en), .dbl_mode(dbl_mode),
    .xon_any(xon_any), .xon1(xon1), .xon2(xon2), .xoff1(xoff1),
    .xoff2(xoff2), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .xoff_clr(xoff_clr), .fwd_valid(fwd_valid),
    .fwd_data(fwd_data), .tx_paused(tx_paused), .xoff_flag(xoff_flag)
  );

  xfc_tx_request #(.DW(DW), .LVL_W(LVL_W)) i_req (
    .clk(clk), .rst(rst), .flow_en(flow_en), .dbl_mode(dbl_mode),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
    .rx_level(rx_level), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
    .fc_ack(fc_ack), .fc_req(fc_req), .fc_char(fc_char)
  );
endmodule

// File: rtl/xfc_flow_ctrl_chk.sv
module xfc_flow_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic flow_en,
  input logic rx_valid,
  input logic rx_err,
  input logic fwd_valid,
  input logic tx_paused,
  input logic xoff_flag,
  input logic xoff_clr,
  input logic fc_req,
  input logic fc_ack
);
  // R8: input rule, strobes never on consecutive cycles
  a_r8_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R7: an errored byte always produces a forwarded byte next cycle
  a_r7_err_forwarded: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_err |=> fwd_valid);

  // R2: a pause only starts after a clean strobe with flow control on
  a_r2_pause_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_paused) |-> $past(rx_valid && !rx_err && flow_en));

  // R2: the flag rises together with the pause
  a_r2_flag_with_pause: assert property (@(posedge clk) disable iff (rst)
    $rose(xoff_flag) |-> tx_paused);

  // R9: flag is sticky without a clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    xoff_flag && !xoff_clr |=> xoff_flag);

  // R12: request holds until acknowledged
  a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
    fc_req && !fc_ack && flow_en |=> fc_req);

  // R13: disabled flow control leaves no pause and no request
  a_r13_no_pause_off: assert property (@(posedge clk) disable iff (rst)
    !flow_en |=> !tx_paused);
  a_r13_no_req_off: assert property (@(posedge clk) disable iff (rst)
    !flow_en |=> !fc_req);
endmodule

bind xfc_flow_ctrl xfc_flow_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .flow_en(flow_en), .rx_valid(rx_valid),
  .rx_err(rx_err), .fwd_valid(fwd_valid), .tx_paused(tx_paused),
  .xoff_flag(xoff_flag), .xoff_clr(xoff_clr), .fc_req(fc_req),
  .fc_ack(fc_ack)
);

// File: tb/test_xfc_flow_ctrl.sv
module test_xfc_flow_ctrl;
  localparam int LVL_W = 7;
  localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h91, OFF1 = 8'h13, OFF2 = 8'h93;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flow_en = 1'b1, dbl_mode = 1'b0, xon_any = 1'b0;
  logic rx_valid = 1'b0, rx_err = 1'b0, xoff_clr = 1'b0, fc_ack = 1'b0;
  logic [7:0] rx_data = '0;
  logic [LVL_W-1:0] rx_level = '0, halt_lvl = 7'd48, resume_lvl = 7'd16;
  logic fwd_valid, tx_paused, xoff_flag, fc_req;
  logic [7:0] fwd_data, fc_char;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  xfc_flow_ctrl i_xfc_flow_ctrl (
    .clk(clk), .rst(rst), .flow_en(flow_en), .dbl_mode(dbl_mode),
    .xon_any(xon_any), .xon1(ON1), .xon2(ON2), .xoff1(OFF1), .xoff2(OFF2),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .tx_paused(tx_paused),
    .xoff_flag(xoff_flag), .xoff_clr(xoff_clr), .rx_level(rx_level),
    .halt_lvl(halt_lvl), .resume_lvl(resume_lvl), .fc_req(fc_req),
    .fc_char(fc_char), .fc_ack(fc_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: strobe one byte, optionally queue it as expected FIFO data
  task automatic send(input logic [7:0] b, input bit err, input bit fwd);
    if (fwd) exp_q.push_back(b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_err = err;
    @(negedge clk); rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_level(input logic [LVL_W-1:0] v);
    @(negedge clk); rx_level = v;
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); fc_ack = 1'b1;
    @(negedge clk); fc_ack = 1'b0;
  endtask

  // monitor: compare each forwarded byte with the queue head
  always @(negedge clk) begin
    if (!rst && fwd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected forward", fwd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(fwd_data == e, "R8/R5 forwarded byte", fwd_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk(!tx_paused && !xoff_flag && !fc_req && !fwd_valid, "R1 reset state",
        {tx_paused, xoff_flag, fc_req, fwd_valid}, 0);

    // R8 plain data, single mode
    send(8'h41, 0, 1); idle(1);
    chk(!tx_paused, "R8 no pause on data", tx_paused, 0);
    // R2 single pause
    send(OFF1, 0, 0);
    chk(tx_paused, "R2 pause set", tx_paused, 1);
    chk(xoff_flag, "R2 flag set", xoff_flag, 1);
    idle(1);
    send(8'h42, 0, 1); idle(1);
    chk(tx_paused, "R8 data keeps pause", tx_paused, 1);
    chk(xoff_flag, "R9 flag sticky", xoff_flag, 1);
    @(negedge clk); xoff_clr = 1'b1;
    @(negedge clk); xoff_clr = 1'b0;
    chk(!xoff_flag, "R9 flag cleared", xoff_flag, 0);
    // R3 single resume
    send(ON1, 0, 0);
    chk(!tx_paused, "R3 pause released", tx_paused, 1'b0);
    idle(1);
    // R7 errored pause character forwarded, no pause
    send(OFF1, 1, 1); idle(1);
    chk(!tx_paused, "R7 errored byte no match", tx_paused, 0);

    // R4 pair mode
    dbl_mode = 1'b1;
    send(OFF1, 0, 0); idle(1);
    chk(!tx_paused, "R4 half pair no pause", tx_paused, 0);
    send(OFF2, 0, 0); idle(1);
    chk(tx_paused, "R4 pair pause", tx_paused, 1);
    send(ON1, 0, 0); idle(1);
    send(ON2, 0, 0); idle(1);
    chk(!tx_paused, "R4 pair resume", tx_paused, 0);
    // R5 broken pair
    send(OFF1, 0, 0); idle(1);
    exp_q.push_back(OFF1);
    send(8'h55, 0, 1); idle(1);
    chk(!tx_paused, "R5 broken pair no pause", tx_paused, 0);
    // R5 breaker is itself a first character
    send(ON1, 0, 0); idle(1);
    exp_q.push_back(ON1);
    send(OFF1, 0, 0); idle(1);
    send(OFF2, 0, 0); idle(1);
    chk(tx_paused, "R5 breaker starts new pair", tx_paused, 1);
    // R6 xon-any
    xon_any = 1'b1;
    send(8'h66, 0, 1); idle(1);
    chk(!tx_paused, "R6 any char releases", tx_paused, 0);
    xon_any = 1'b0;

    // R13 disable flow control
    dbl_mode = 1'b0;
    send(OFF1, 0, 0); idle(1);
    chk(tx_paused, "R2 paused before disable", tx_paused, 1);
    @(negedge clk); flow_en = 1'b0;
    @(negedge clk);
    chk(!tx_paused, "R13 pause dropped", tx_paused, 0);
    send(OFF1, 0, 1); idle(1);
    chk(!tx_paused, "R13 no match when off", tx_paused, 0);
    set_level(7'd60); idle(2);
    chk(!fc_req, "R13 no request when off", fc_req, 0);
    set_level(7'd10);
    @(negedge clk); flow_en = 1'b1;
    idle(2);

    // R10/R11 single mode requests
    set_level(7'd48);
    chk(fc_req && fc_char == OFF1, "R10 pause request", fc_char, OFF1);
    idle(3);
    chk(fc_req, "R12 held without ack", fc_req, 1);
    ack();
    chk(!fc_req, "R12 single ack drops", fc_req, 0);
    set_level(7'd55); idle(2);
    chk(!fc_req, "R10 only once", fc_req, 0);
    set_level(7'd20); idle(1);
    chk(!fc_req, "R11 not yet at resume", fc_req, 0);
    set_level(7'd16);
    chk(fc_req && fc_char == ON1, "R11 resume request", fc_char, ON1);
    ack();

    // R12 pair mode requests
    dbl_mode = 1'b1;
    set_level(7'd50);
    chk(fc_req && fc_char == OFF1, "R12 first of pair", fc_char, OFF1);
    ack();
    chk(fc_req && fc_char == OFF2, "R12 second of pair", fc_char, OFF2);
    ack();
    chk(!fc_req, "R12 pair done", fc_req, 0);

    idle(3);
    chk(exp_q.size() == 0, "R8 all forwards seen", exp_q.size(), 0);
    finish_run();
  end
endmodule